// File: doc/BRIEF.md
# Calendar Alarm Comparator

This block watches the running calendar time of a real-time clock and flags the moment it reaches a programmed alarm point. Six alarm fields can be programmed: seconds, minutes, hours, day of week, day of month and month. Each field holds a BCD target in its low seven bits and a per-field compare-enable in its top bit. Only the enabled fields are compared, so software can form an alarm from any subset, such as "every day at 07:30" or "the first of every month". A field written as zero takes no part in the match.

The clock counter drives the six current time values, which are seven-bit BCD, together with a single-cycle strobe on each cycle those values change. The match is taken only on that strobe. A hit sets a sticky alarm flag in the control register. The flag drives the interrupt output when the alarm interrupt enable is set. Software reaches the alarm fields and the control register through a simple indexed register port: writes are synchronous and reads are combinational.

Top module: `cal_alarm_cmp`

## Requirements
- R1: Writing index 8, 9, 10, 11, 12 or 13 stores the 8-bit write data as the alarm field for seconds, minutes, hours, day of week, day of month and month, in that order. A read of the same index returns the stored value.
- R2: In each alarm field, bit 7 enables the compare for that field and bits 6:0 hold the BCD target. The target is compared with the matching 7-bit time input.
- R3: A field with bit 7 clear does not take part in the match, whatever its target bits hold. A field written as 0x00 is ignored.
- R4: The month field is compared directly against the month input in the same encoding, with months numbered 1 to 12. Month 12 (0x12) and month 1 (0x01) both match.
- R5: On a cycle with the update strobe high, if at least one field is enabled and every enabled field equals its time input, the alarm flag is set on that clock edge. The flag reads as bit 0 of control index 14.
- R6: When the update strobe is low, the alarm flag is not set, even if the time inputs equal all the enabled targets.
- R7: When no field has its enable bit set, the alarm flag is never set.
- R8: Once set, the alarm flag stays set, including through later strobes that do not match. It clears only on a write to index 14 with bit 0 at 0; a write with bit 0 at 1 leaves it unchanged. Each write to index 14 loads bit 3 as the alarm interrupt enable, and bit 3 reads back the stored enable.
- R9: The interrupt output is high exactly when the alarm flag and the alarm interrupt enable are both set.
- R10: After reset, all six alarm fields, the flag and the interrupt enable read as zero, and the interrupt output is low.
- R11: If a flag-clearing write to index 14 lands on the same cycle as a match, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe; the time inputs changed this cycle |
| sec_i | input | 7 | Current seconds, BCD |
| min_i | input | 7 | Current minutes, BCD |
| hour_i | input | 7 | Current hours, BCD |
| wday_i | input | 7 | Current day of week, BCD |
| mday_i | input | 7 | Current day of month, BCD |
| mon_i | input | 7 | Current month 1..12, BCD |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register index |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from index |
| alarm_irq_o | output | 1 | Alarm interrupt request |

## Verification
Several properties are checked on every cycle:
- Every write to an alarm index lands in the matching field.
- The flag only rises after a strobe cycle on which the match logic reported a hit and some field was enabled.
- The flag only falls after a clearing write.

Only the bench scenarios can show that the right fields take part in a match: partial subsets, a month at the ends of its range, an all-zero alarm, and a mismatch in a single field. The same holds for the set-wins priority when a set and a clear collide, and for the interrupt gating as seen at the port.

// File: rtl/cal_alarm_pkg.sv
// Shared widths, indexes and bit positions for the calendar alarm comparator.
package cal_alarm_pkg;
    localparam int FIELD_W    = 8;   // width of one alarm register
    localparam int VAL_W      = 7;   // BCD value bits in a field / time input
    localparam int NUM_FIELDS = 6;   // sec, min, hour, wday, mday, month
    localparam int ADDR_W     = 4;   // register index width
    localparam int BASE_IDX   = 8;   // first alarm register index
    localparam int CTRL_IDX   = 14;  // control register index
    localparam int EN_BIT     = FIELD_W - 1;
    localparam int FLAG_BIT   = 0;
    localparam int AIE_BIT    = 3;

    typedef logic [NUM_FIELDS-1:0][FIELD_W-1:0] alarm_vec_t;
    typedef logic [NUM_FIELDS-1:0][VAL_W-1:0]   time_vec_t;
endpackage

// File: rtl/cal_alarm_regs.sv
// Alarm field storage and register read mux.
// Assumes: one write per cycle; reads are combinational from the index;
// the control register contents come from cal_alarm_ctrl.
module cal_alarm_regs
    import cal_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [FIELD_W-1:0] wdata,
    input  logic              flag,
    input  logic              aie,
    output alarm_vec_t        alarm_q,
    output logic              ctrl_wr,
    output logic [FIELD_W-1:0] rdata
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_IDX);

    genvar k;
    generate
        for (k = 0; k < NUM_FIELDS; k++) begin : g_field
            localparam logic [ADDR_W-1:0] IDX = ADDR_W'(BASE_IDX + k);

            // Holds one alarm field; loaded by a write to its own index.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    alarm_q[k] <= '0;
                else if (we && addr == IDX)
                    alarm_q[k] <= wdata;
            end

            p_field_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
                (we && addr == IDX) |=> (alarm_q[k] == $past(wdata)));
        end
    endgenerate

    // Decode a write aimed at the control register.
    assign ctrl_wr = we && (addr == CTRL_A);

    // Read mux over alarm fields and control bits.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (addr == ADDR_W'(BASE_IDX + i))
                rdata = alarm_q[i];
        end
        if (addr == CTRL_A) begin
            rdata[FLAG_BIT] = flag;
            rdata[AIE_BIT]  = aie;
        end
    end
endmodule

// File: rtl/cal_alarm_match.sv
// Per-field masked compare of alarm targets against the running time.
// Assumes: time inputs are stable on the strobe cycle; a field with its
// enable bit clear is a don't-care; an all-disabled alarm never hits.
module cal_alarm_match
    import cal_alarm_pkg::*;
(
    input  logic       tick,
    input  alarm_vec_t alarm_q,
    input  time_vec_t  now,
    output logic       any_en,
    output logic       hit
);
    logic [NUM_FIELDS-1:0] fld_ok;
    logic [NUM_FIELDS-1:0] fld_en;

    genvar k;
    generate
        for (k = 0; k < NUM_FIELDS; k++) begin : g_cmp
            // One field passes when disabled or when its target equals the time.
            assign fld_en[k] = alarm_q[k][EN_BIT];
            assign fld_ok[k] = !fld_en[k] || (alarm_q[k][VAL_W-1:0] == now[k]);
        end
    endgenerate

    // Combine: strobe, at least one enabled field, all fields passing.
    assign any_en = |fld_en;
    assign hit    = tick && any_en && (&fld_ok);
endmodule

// File: rtl/cal_alarm_ctrl.sv
// Sticky alarm flag, interrupt enable and interrupt gate.
// Assumes: a hit and a clear in the same cycle resolve to set.
module cal_alarm_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic ctrl_wr,
    input  logic clr_req,
    input  logic aie_wr,
    output logic flag_q,
    output logic aie_q,
    output logic irq
);
    // Flag: set on hit, cleared by software, set wins a tie.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (hit)
            flag_q <= 1'b1;
        else if (clr_req)
            flag_q <= 1'b0;
    end

    // Interrupt enable: loaded on every control write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            aie_q <= 1'b0;
        else if (ctrl_wr)
            aie_q <= aie_wr;
    end

    // Interrupt request gate.
    assign irq = flag_q && aie_q;

    p_flag_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(hit));

    p_flag_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> $past(clr_req));

    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && clr_req) |=> flag_q);
endmodule

// File: rtl/cal_alarm_cmp.sv
// Top: calendar alarm comparator with register port and interrupt.
// Assumes: tick_i is high for one cycle per time update from the counter.
module cal_alarm_cmp
    import cal_alarm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic [VAL_W-1:0]   sec_i,
    input  logic [VAL_W-1:0]   min_i,
    input  logic [VAL_W-1:0]   hour_i,
    input  logic [VAL_W-1:0]   wday_i,
    input  logic [VAL_W-1:0]   mday_i,
    input  logic [VAL_W-1:0]   mon_i,
    input  logic               reg_we_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [FIELD_W-1:0] reg_wdata_i,
    output logic [FIELD_W-1:0] reg_rdata_o,
    output logic               alarm_irq_o
);
    alarm_vec_t alarm_q;
    time_vec_t  now;
    logic       ctrl_wr, hit, any_en, flag_q, aie_q;

    // Pack time inputs in field order (index 0 = seconds).
    assign now = {mon_i, mday_i, wday_i, hour_i, min_i, sec_i};

    cal_alarm_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we_i),
        .addr    (reg_addr_i),
        .wdata   (reg_wdata_i),
        .flag    (flag_q),
        .aie     (aie_q),
        .alarm_q (alarm_q),
        .ctrl_wr (ctrl_wr),
        .rdata   (reg_rdata_o)
    );

    cal_alarm_match u_match (
        .tick    (tick_i),
        .alarm_q (alarm_q),
        .now     (now),
        .any_en  (any_en),
        .hit     (hit)
    );

    cal_alarm_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .ctrl_wr (ctrl_wr),
        .clr_req (ctrl_wr && !reg_wdata_i[FLAG_BIT]),
        .aie_wr  (reg_wdata_i[AIE_BIT]),
        .flag_q  (flag_q),
        .aie_q   (aie_q),
        .irq     (alarm_irq_o)
    );

    p_rise_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(tick_i));

    p_rise_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(any_en));

    p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq_o |-> (flag_q && aie_q));
endmodule

// File: tb/tb_cal_alarm_cmp.sv
`timescale 1ns/1ps
module tb_cal_alarm_cmp;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [6:0] t_sec = '0, t_min = '0, t_hour = '0, t_wday = '0, t_mday = '0, t_mon = '0;
    logic       we = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cal_alarm_cmp dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .sec_i(t_sec), .min_i(t_min), .hour_i(t_hour),
        .wday_i(t_wday), .mday_i(t_mday), .mon_i(t_mon),
        .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .alarm_irq_o(irq)
    );

    // Vector: alarms sec..mon (6x8), times sec..mon (6x8), expected flag.
    localparam int NV = 8;
    localparam logic [96:0] VEC [NV] = '{
        {48'hB0_00_00_00_00_00, 48'h30_12_08_03_15_06, 1'b1}, // R2 R3 sec only
        {48'hB0_00_00_00_00_00, 48'h31_12_08_03_15_06, 1'b0}, // R2 sec differs
        {48'hC5_D9_A3_86_B1_92, 48'h45_59_23_06_31_12, 1'b1}, // R4 month 12, all on
        {48'hC5_D9_A3_86_B1_92, 48'h45_59_23_06_31_11, 1'b0}, // R4 month differs
        {48'h00_00_00_00_00_00, 48'h00_00_00_00_00_00, 1'b0}, // R7 nothing enabled
        {48'h00_00_00_00_00_81, 48'h17_40_09_05_20_01, 1'b1}, // R4 month 1 only
        {48'h00_00_87_82_00_00, 48'h11_22_07_02_09_04, 1'b1}, // R3 hour+wday
        {48'h00_00_87_82_00_00, 48'h11_22_07_03_09_04, 1'b0}  // R3 wday differs
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); we = 1'b1; addr = a; wdata = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        addr = a; #0.5; d = rdata;
    endtask

    task automatic set_time(input logic [47:0] t);
        t_sec = t[46:40]; t_min = t[38:32]; t_hour = t[30:24];
        t_wday = t[22:16]; t_mday = t[14:8]; t_mon = t[6:0];
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic load_alarms(input logic [47:0] a);
        for (int i = 0; i < 6; i++) wr(4'(8 + i), a[47 - 8*i -: 8]);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        for (int i = 8; i <= 14; i++) begin
            rd(4'(i), v); check("R10 reset reg", v, 8'h00);
        end
        check("R10 irq", {7'd0, irq}, 8'h00);

        // R1: read back each alarm field
        load_alarms(48'h81_92_A3_34_45_56);
        rd(4'd8, v);  check("R1 sec", v, 8'h81);
        rd(4'd9, v);  check("R1 min", v, 8'h92);
        rd(4'd10, v); check("R1 hour", v, 8'hA3);
        rd(4'd11, v); check("R1 wday", v, 8'h34);
        rd(4'd12, v); check("R1 mday", v, 8'h45);
        rd(4'd13, v); check("R1 mon", v, 8'h56);

        // Table walk: R2 R3 R4 R5 R7
        for (int n = 0; n < NV; n++) begin
            wr(4'd14, 8'h00);
            load_alarms(VEC[n][96:49]);
            set_time(VEC[n][48:1]);
            pulse_tick();
            rd(4'd14, v);
            check($sformatf("R5 vector %0d flag", n), {7'd0, v[0]}, {7'd0, VEC[n][0]});
        end

        // R6: full match held without a strobe
        wr(4'd14, 8'h00);
        load_alarms(48'hC5_D9_A3_86_B1_92);
        set_time(48'h45_59_23_06_31_12);
        repeat (4) @(negedge clk);
        rd(4'd14, v); check("R6 no tick no flag", v, 8'h00);

        // R5 then R8: sticky through mismatching strobe
        pulse_tick();
        rd(4'd14, v); check("R5 flag set", v, 8'h01);
        set_time(48'h46_59_23_06_31_12);
        pulse_tick();
        rd(4'd14, v); check("R8 sticky on mismatch", v, 8'h01);

        // R8: write bit0=1 keeps flag; R9 irq low while enable clear
        wr(4'd14, 8'h01);
        rd(4'd14, v); check("R8 write one keeps flag", v, 8'h01);
        check("R9 irq off without enable", {7'd0, irq}, 8'h00);
        wr(4'd14, 8'h09);
        rd(4'd14, v); check("R8 enable readback", v, 8'h09);
        check("R9 irq on", {7'd0, irq}, 8'h01);
        wr(4'd14, 8'h08);
        rd(4'd14, v); check("R8 clear flag keep enable", v, 8'h08);
        check("R9 irq off after clear", {7'd0, irq}, 8'h00);

        // R11: clear write and match on same cycle
        set_time(48'h45_59_23_06_31_12);
        @(negedge clk); tick = 1'b1; we = 1'b1; addr = 4'd14; wdata = 8'h08;
        @(negedge clk); tick = 1'b0; we = 1'b0;
        rd(4'd14, v); check("R11 set wins", v, 8'h09);
        check("R9 irq after collision", {7'd0, irq}, 8'h01);

        // R3: enable bit clear with nonzero target is ignored
        wr(4'd14, 8'h00);
        load_alarms(48'h33_00_00_00_00_81);
        set_time(48'h10_00_00_00_00_01);
        pulse_tick();
        rd(4'd14, v); check("R3 disabled target ignored", v, 8'h01);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule